// File: doc/BRIEF.md
# Quadrature Encoder Position and Rotation Tracker

This block turns the two phase lines of an incremental encoder, and an optional once-per-turn index line, into a bounded position count, a turn count and a direction flag. The phase lines are resynchronised to the core clock. Each legal Gray-code step between adjacent phase states is read as one unit of motion forward or backward. A step in which both lines change at once is dropped as noise.

The position count runs from zero up to a programmable ceiling and wraps at both ends. The turn count is 12 bits wide. Its source is chosen by configuration: either the index edges, counted in the current direction, or the wrap events of the position count. Three sticky event flags report a turn count overflow, a turn count underflow, and a turn count reaching a programmed compare value. Software clears each flag by pulsing its clear bit.

An optional start-up mode waits until the synchronisers hold real input values, then adopts the phase lines as the reference state without counting. A status bit reports when this has finished.

Top module: `qdec_top`

## Requirements
- R1: `enc_a` and `enc_b` pass through a two-stage synchroniser. `phase_ab` shows `{A,B}` (A in bit 1) as sampled three rising edges earlier.
- R2: Phase positions are ordered 00, 10, 11, 01 (as `{A,B}`). A move to the next position in that cycle is an up transition; a move to the previous one is a down transition. `dir_up` becomes 1 after an up transition and 0 after a down transition.
- R3: A change of both phase lines between consecutive synchronised samples is ignored. Neither the position nor `dir_up` changes.
- R4: With `cfg_half_rate`=0 every accepted transition steps the position. With `cfg_half_rate`=1 the position steps once per two net transitions in the same direction, and opposite transitions cancel.
- R5: An up step at or above `cfg_max_pos` loads 0; this is a position overflow. A down step at 0 loads `cfg_max_pos`; this is a position underflow. Any other step is ±1.
- R6: An index pulse is a rising edge of the synchronised index while `cfg_idx_en`=1. When `cfg_idx_clears_pos`=1, an index pulse clears the position and the half-rate accumulator, and it takes priority over a step in the same cycle.
- R7: When `cfg_idx_en`=1 and `cfg_rot_by_wrap`=0, each index pulse changes the turn count by +1 if `dir_up` was 1 before that cycle, and by −1 otherwise.
- R8: In every other configuration the turn count changes by +1 on a position overflow and by −1 on a position underflow, and index pulses leave it unchanged.
- R9: A turn count step from 0xFFF to 0 sets `irq_flags[0]`. A step from 0 to 0xFFF sets `irq_flags[1]`.
- R10: `irq_flags[2]` is set in the cycle the turn count steps to a value equal to `cfg_rot_cmp`.
- R11: Flags stay set until the matching `irq_clr` bit is 1 at a clock edge. A set in the same cycle wins over the clear.
- R12: With `cfg_autoload_en`=1, `autoload_done` is 0 after reset and becomes 1 on the third edge after reset is released. Transitions seen before that are not counted, and the bit stays 1 until reset.
- R13: Reset sets the position, turn count, direction, phase, flags and `autoload_done` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| enc_a | input | 1 | Encoder phase A, asynchronous |
| enc_b | input | 1 | Encoder phase B, asynchronous |
| enc_idx | input | 1 | Encoder index, asynchronous |
| cfg_max_pos | input | 16 | Position ceiling |
| cfg_half_rate | input | 1 | 1: one step per two transitions |
| cfg_idx_en | input | 1 | Index input enable |
| cfg_rot_by_wrap | input | 1 | 1: turn count follows position wraps |
| cfg_idx_clears_pos | input | 1 | Index pulse clears position |
| cfg_rot_cmp | input | 12 | Turn count compare value |
| cfg_autoload_en | input | 1 | Start-up phase adoption enable |
| irq_clr | input | 3 | Write-one-to-clear for the flags |
| pos_count | output | 16 | Position count |
| rot_count | output | 12 | Turn count |
| phase_ab | output | 2 | Synchronised {A,B} state |
| dir_up | output | 1 | 1 = increasing, 0 = decreasing |
| autoload_done | output | 1 | Start-up adoption complete |
| irq_flags | output | 3 | [0] turn overflow, [1] turn underflow, [2] compare |

## Verification
The assertions check on every cycle that the position moves only by one, to zero or to the ceiling, and that the turn count moves by at most one. They also check that a double-line phase change leaves direction and position alone, that each flag rises only on its own event and falls only under its clear bit, and that the start-up status never drops. The source selection for the turn count, the half-rate cancellation, the priority of an index clear and the exact wrap values depend on configuration sequences and stimulus history. Only the bench scenarios, compared against the reference model, can show these.

// File: rtl/qdec_pkg.sv
package qdec_pkg;
  typedef enum logic [1:0] {
    STEP_NONE = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DN   = 2'd2
  } step_e;

  localparam int IRQ_W   = 3;
  localparam int IRQ_OVF = 0;
  localparam int IRQ_UNF = 1;
  localparam int IRQ_CMP = 2;
endpackage

// File: rtl/qdec_sync.sv
module qdec_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain[s] <= '0;
        else if (s == 0) chain[s] <= d;
        else chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/qdec_phase.sv
module qdec_phase
  import qdec_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] ab_s,
  input  logic       idx_s,
  input  logic       decode_en,
  input  logic       half_rate,
  input  logic       idx_en,
  input  logic       clr_on_idx,
  output logic [1:0] phase_q,
  output logic       dir_q,
  output logic       idx_pulse,
  output logic       pos_clr,
  output step_e      step
);
  logic              idx_prev_q;
  logic signed [1:0] acc_q, acc_d;
  logic [1:0]        delta;
  logic              tr_up, tr_dn;

  function automatic logic [1:0] ring_pos(input logic [1:0] ab);
    return {ab[0], ab[1] ^ ab[0]};
  endfunction

  assign delta     = ring_pos(ab_s) - ring_pos(phase_q);
  assign tr_up     = decode_en && (delta == 2'd1);
  assign tr_dn     = decode_en && (delta == 2'd3);
  assign idx_pulse = idx_en && idx_s && !idx_prev_q;
  assign pos_clr   = idx_pulse && clr_on_idx;

  always_comb begin
    step  = STEP_NONE;
    acc_d = acc_q;
    if (pos_clr) begin
      acc_d = '0;
    end else if (tr_up) begin
      if (!half_rate) step = STEP_UP;
      else if (acc_q == 2'sd1) begin
        step  = STEP_UP;
        acc_d = '0;
      end else acc_d = acc_q + 2'sd1;
    end else if (tr_dn) begin
      if (!half_rate) step = STEP_DN;
      else if (acc_q == -2'sd1) begin
        step  = STEP_DN;
        acc_d = '0;
      end else acc_d = acc_q - 2'sd1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q    <= '0;
      idx_prev_q <= 1'b0;
      acc_q      <= '0;
      dir_q      <= 1'b0;
    end else begin
      phase_q    <= ab_s;
      idx_prev_q <= idx_s;
      acc_q      <= acc_d;
      if (tr_up) dir_q <= 1'b1;
      else if (tr_dn) dir_q <= 1'b0;
    end
  end
endmodule

// File: rtl/qdec_pos.sv
module qdec_pos
  import qdec_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  step_e        step,
  input  logic         clr,
  input  logic [W-1:0] max_pos,
  output logic [W-1:0] pos_q,
  output logic         wrap_up,
  output logic         wrap_dn
);
  assign wrap_up = !clr && (step == STEP_UP) && (pos_q >= max_pos);
  assign wrap_dn = !clr && (step == STEP_DN) && (pos_q == '0);

  always_ff @(posedge clk) begin
    if (rst || clr) pos_q <= '0;
    else if (step == STEP_UP) pos_q <= wrap_up ? '0 : pos_q + W'(1);
    else if (step == STEP_DN) pos_q <= wrap_dn ? max_pos : pos_q - W'(1);
  end
endmodule

// File: rtl/qdec_rot.sv
module qdec_rot
  import qdec_pkg::*;
#(
  parameter int W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  input  logic             dec,
  input  logic [W-1:0]     cmp_val,
  input  logic [IRQ_W-1:0] irq_clr,
  output logic [W-1:0]     rot_q,
  output logic [IRQ_W-1:0] irq_q
);
  logic [W-1:0]     rot_d;
  logic [IRQ_W-1:0] set;

  always_comb begin
    if (inc) rot_d = rot_q + W'(1);
    else if (dec) rot_d = rot_q - W'(1);
    else rot_d = rot_q;
    set          = '0;
    set[IRQ_OVF] = inc && (&rot_q);
    set[IRQ_UNF] = dec && (rot_q == '0);
    set[IRQ_CMP] = (inc || dec) && (rot_d == cmp_val);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rot_q <= '0;
      irq_q <= '0;
    end else begin
      rot_q <= rot_d;
      irq_q <= (irq_q & ~irq_clr) | set;
    end
  end
endmodule

// File: rtl/qdec_top.sv
module qdec_top
  import qdec_pkg::*;
#(
  parameter int POS_W       = 16,
  parameter int ROT_W       = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enc_a,
  input  logic             enc_b,
  input  logic             enc_idx,
  input  logic [POS_W-1:0] cfg_max_pos,
  input  logic             cfg_half_rate,
  input  logic             cfg_idx_en,
  input  logic             cfg_rot_by_wrap,
  input  logic             cfg_idx_clears_pos,
  input  logic [ROT_W-1:0] cfg_rot_cmp,
  input  logic             cfg_autoload_en,
  input  logic [2:0]       irq_clr,
  output logic [POS_W-1:0] pos_count,
  output logic [ROT_W-1:0] rot_count,
  output logic [1:0]       phase_ab,
  output logic             dir_up,
  output logic             autoload_done,
  output logic [2:0]       irq_flags
);
  localparam int FILL_W = $clog2(SYNC_STAGES + 1);

  logic [2:0]        sync_q;
  logic [FILL_W-1:0] fill_q;
  logic              done_q, decode_en;
  logic              idx_pulse, pos_clr, wrap_up, wrap_dn;
  logic              idx_mode, rot_inc, rot_dec;
  step_e             step;

  qdec_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d({enc_a, enc_b, enc_idx}), .q(sync_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      fill_q <= '0;
      done_q <= 1'b0;
    end else begin
      if (fill_q != FILL_W'(SYNC_STAGES)) fill_q <= fill_q + FILL_W'(1);
      if (cfg_autoload_en && fill_q == FILL_W'(SYNC_STAGES)) done_q <= 1'b1;
    end
  end

  assign decode_en = !cfg_autoload_en || done_q;

  qdec_phase u_phase (
    .clk(clk), .rst(rst), .ab_s(sync_q[2:1]), .idx_s(sync_q[0]),
    .decode_en(decode_en), .half_rate(cfg_half_rate), .idx_en(cfg_idx_en),
    .clr_on_idx(cfg_idx_clears_pos), .phase_q(phase_ab), .dir_q(dir_up),
    .idx_pulse(idx_pulse), .pos_clr(pos_clr), .step(step)
  );

  qdec_pos #(.W(POS_W)) u_pos (
    .clk(clk), .rst(rst), .step(step), .clr(pos_clr), .max_pos(cfg_max_pos),
    .pos_q(pos_count), .wrap_up(wrap_up), .wrap_dn(wrap_dn)
  );

  assign idx_mode = cfg_idx_en && !cfg_rot_by_wrap;
  assign rot_inc  = idx_mode ? (idx_pulse && dir_up)  : wrap_up;
  assign rot_dec  = idx_mode ? (idx_pulse && !dir_up) : wrap_dn;

  qdec_rot #(.W(ROT_W)) u_rot (
    .clk(clk), .rst(rst), .inc(rot_inc), .dec(rot_dec), .cmp_val(cfg_rot_cmp),
    .irq_clr(irq_clr), .rot_q(rot_count), .irq_q(irq_flags)
  );

  assign autoload_done = done_q;
endmodule

// File: rtl/qdec_checker.sv
module qdec_checker #(
  parameter int POS_W = 16,
  parameter int ROT_W = 12
) (
  input logic             clk,
  input logic             rst,
  input logic [POS_W-1:0] pos_count,
  input logic [POS_W-1:0] cfg_max_pos,
  input logic [ROT_W-1:0] rot_count,
  input logic [ROT_W-1:0] cfg_rot_cmp,
  input logic [1:0]       phase_ab,
  input logic             dir_up,
  input logic             autoload_done,
  input logic [2:0]       irq_flags,
  input logic [2:0]       irq_clr
);
  assert_pos_move_R5: assert property (@(posedge clk) disable iff (rst)
    (pos_count == $past(pos_count)) || (pos_count == POS_W'($past(pos_count) + 1'b1)) ||
    (pos_count == POS_W'($past(pos_count) - 1'b1)) || (pos_count == '0) ||
    (pos_count == $past(cfg_max_pos)));

  assert_rot_move_R8: assert property (@(posedge clk) disable iff (rst)
    (rot_count == $past(rot_count)) || (rot_count == ROT_W'($past(rot_count) + 1'b1)) ||
    (rot_count == ROT_W'($past(rot_count) - 1'b1)));

  assert_double_change_R3: assert property (@(posedge clk) disable iff (rst)
    ((phase_ab ^ $past(phase_ab)) == 2'b11) |->
      ((dir_up == $past(dir_up)) && ((pos_count == $past(pos_count)) || (pos_count == '0))));

  assert_dir_needs_phase_R2: assert property (@(posedge clk) disable iff (rst)
    !$stable(dir_up) |-> !$stable(phase_ab));

  assert_ovf_flag_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_flags[0]) |-> (($past(rot_count) == '1) && (rot_count == '0)));

  assert_unf_flag_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_flags[1]) |-> (($past(rot_count) == '0) && (rot_count == '1)));

  assert_cmp_flag_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_flags[2]) |-> (rot_count == $past(cfg_rot_cmp)));

  assert_sticky_R11: assert property (@(posedge clk) disable iff (rst)
    (($past(irq_flags) & ~irq_flags & ~$past(irq_clr)) == 3'b000));

  assert_done_hold_R12: assert property (@(posedge clk) disable iff (rst)
    !$fell(autoload_done));
endmodule

bind qdec_top qdec_checker #(.POS_W(POS_W), .ROT_W(ROT_W)) u_chk (
  .clk(clk), .rst(rst), .pos_count(pos_count), .cfg_max_pos(cfg_max_pos),
  .rot_count(rot_count), .cfg_rot_cmp(cfg_rot_cmp), .phase_ab(phase_ab),
  .dir_up(dir_up), .autoload_done(autoload_done), .irq_flags(irq_flags),
  .irq_clr(irq_clr)
);

// File: tb/qdec_top_test.sv
module qdec_top_test;
  logic clk = 0, rst = 1;
  logic enc_a = 1, enc_b = 1, enc_idx = 0;
  logic [15:0] cfg_max_pos = 16'd5;
  logic cfg_half_rate = 0, cfg_idx_en = 0, cfg_rot_by_wrap = 0, cfg_idx_clears_pos = 0;
  logic [11:0] cfg_rot_cmp = 12'd3;
  logic cfg_autoload_en = 1;
  logic [2:0] irq_clr = 0;
  logic [15:0] pos_count;
  logic [11:0] rot_count;
  logic [1:0] phase_ab;
  logic dir_up, autoload_done;
  logic [2:0] irq_flags;

  int total = 0, bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  qdec_top uut (.*);

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model state
  int m_s1ab = 0, m_s2ab = 0, m_s1i = 0, m_s2i = 0, m_prev = 0, m_previ = 0;
  int m_acc = 0, m_dir = 0, m_pos = 0, m_rot = 0, m_flags = 0, m_cnt = 0, m_done = 0;

  function automatic int ringp(input int ab);
    return ((ab & 1) << 1) | (((ab >> 1) ^ ab) & 1);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_s1ab = 0; m_s2ab = 0; m_s1i = 0; m_s2i = 0; m_prev = 0; m_previ = 0;
      m_acc = 0; m_dir = 0; m_pos = 0; m_rot = 0; m_flags = 0; m_cnt = 0; m_done = 0;
    end else begin
      int d, en, up, dn, ip, clr, sup, sdn, od, ovf, unf, rup, rdn, nrot, setf;
      d = (ringp(m_s2ab) - ringp(m_prev)) & 3;
      en = (!cfg_autoload_en || m_done) ? 1 : 0;
      up = en && d == 1; dn = en && d == 3;
      ip = cfg_idx_en && m_s2i && !m_previ;
      clr = ip && cfg_idx_clears_pos;
      sup = 0; sdn = 0; od = m_dir;
      if (clr) m_acc = 0;
      else if (up) begin
        if (!cfg_half_rate) sup = 1;
        else if (m_acc == 1) begin sup = 1; m_acc = 0; end
        else m_acc++;
      end else if (dn) begin
        if (!cfg_half_rate) sdn = 1;
        else if (m_acc == -1) begin sdn = 1; m_acc = 0; end
        else m_acc--;
      end
      if (up) m_dir = 1; else if (dn) m_dir = 0;
      ovf = 0; unf = 0;
      if (clr) m_pos = 0;
      else if (sup) begin ovf = m_pos >= cfg_max_pos; m_pos = ovf ? 0 : m_pos + 1; end
      else if (sdn) begin unf = m_pos == 0; m_pos = unf ? cfg_max_pos : m_pos - 1; end
      if (cfg_idx_en && !cfg_rot_by_wrap) begin rup = ip && od; rdn = ip && !od; end
      else begin rup = ovf; rdn = unf; end
      nrot = rup ? (m_rot + 1) % 4096 : rdn ? (m_rot + 4095) % 4096 : m_rot;
      setf = 0;
      if (rup && m_rot == 4095) setf |= 1;
      if (rdn && m_rot == 0) setf |= 2;
      if ((rup || rdn) && nrot == cfg_rot_cmp) setf |= 4;
      m_rot = nrot;
      m_flags = (m_flags & ~int'(irq_clr)) | setf;
      if (cfg_autoload_en && m_cnt == 2) m_done = 1;
      if (m_cnt < 2) m_cnt++;
      m_prev = m_s2ab; m_previ = m_s2i;
      m_s2ab = m_s1ab; m_s2i = m_s1i;
      m_s1ab = {enc_a, enc_b}; m_s1i = enc_idx;
    end
    #1;
    if (!finished) begin
      chk("R5 pos", pos_count, m_pos);
      chk("R8 rot", rot_count, m_rot);
      chk("R2 dir", dir_up, m_dir);
      chk("R1 phase", phase_ab, m_prev);
      chk("R11 flags", irq_flags, m_flags);
      chk("R12 done", autoload_done, m_done);
    end
  end

  function automatic logic [1:0] nxt(input logic [1:0] ab, input bit go_up);
    case (ab)
      2'b00: return go_up ? 2'b10 : 2'b01;
      2'b10: return go_up ? 2'b11 : 2'b00;
      2'b11: return go_up ? 2'b01 : 2'b10;
      default: return go_up ? 2'b00 : 2'b11;
    endcase
  endfunction

  task automatic move(input bit go_up, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      {enc_a, enc_b} = nxt({enc_a, enc_b}, go_up);
      repeat (4) @(negedge clk);
    end
  endtask

  task automatic idx_pulse();
    @(negedge clk); enc_idx = 1;
    repeat (3) @(negedge clk); enc_idx = 0;
    repeat (4) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R13 pos reset", pos_count, 0);
    chk("R13 rot reset", rot_count, 0);
    chk("R13 flags reset", irq_flags, 0);
    chk("R13 done reset", autoload_done, 0);
    rst = 0;
    @(negedge clk); @(negedge clk);
    chk("R12 done low while loading", autoload_done, 0);
    repeat (4) @(negedge clk);
    chk("R12 done", autoload_done, 1);
    chk("R12 initial phase not counted", pos_count, 0);
    chk("R1 phase", phase_ab, 3);
    move(1, 7);
    chk("R5 wrap up", pos_count, 1);
    chk("R8 rot on overflow", rot_count, 1);
    chk("R2 dir up", dir_up, 1);
    @(negedge clk); {enc_a, enc_b} = {enc_a, enc_b} ^ 2'b11;
    repeat (4) @(negedge clk);
    chk("R3 illegal pos", pos_count, 1);
    chk("R3 illegal dir", dir_up, 1);
    move(0, 8);
    chk("R5 wrap down", pos_count, 5);
    chk("R9 rot underflow", rot_count, 4095);
    chk("R9 underflow flag", irq_flags, 3'b010);
    @(negedge clk); irq_clr = 3'b111;
    @(negedge clk); irq_clr = 3'b000;
    @(negedge clk);
    chk("R11 cleared", irq_flags, 0);
    move(1, 1);
    chk("R9 overflow flag", irq_flags, 3'b001);
    chk("R9 rot wrapped", rot_count, 0);
    cfg_half_rate = 1;
    move(1, 2);
    chk("R4 half rate two ups", pos_count, 1);
    move(1, 1); move(0, 1);
    chk("R4 cancel", pos_count, 1);
    move(0, 2);
    chk("R4 half rate two downs", pos_count, 0);
    cfg_half_rate = 0;
    move(1, 1);
    cfg_idx_en = 1;
    repeat (3) idx_pulse();
    chk("R7 index counts up", rot_count, 3);
    chk("R7 pos kept", pos_count, 1);
    chk("R10 compare flag", irq_flags, 3'b101);
    cfg_idx_clears_pos = 1;
    idx_pulse();
    chk("R6 index clears pos", pos_count, 0);
    chk("R7 rot", rot_count, 4);
    cfg_rot_by_wrap = 1;
    idx_pulse();
    chk("R8 index ignored", rot_count, 4);
    cfg_rot_by_wrap = 0;
    move(0, 1);
    chk("R8 wrap ignored in index mode", rot_count, 4);
    chk("R5 down wrap", pos_count, 5);
    idx_pulse();
    chk("R7 index counts down", rot_count, 3);
    chk("R6 cleared again", pos_count, 0);
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule